// File: doc/BRIEF.md
# Quad Digital Potentiometer Serial Controller

This block is the digital control core of a four-channel, 64-step variable resistor. A host drives a three-wire serial port (active-low select, serial clock, serial data in) to send 8-bit command words. Each word names one of four channels and gives a 6-bit wiper code. When a complete word has arrived, the code is written into that channel's wiper latch. Each channel then drives the resistor ladder with a tap-select code, plus two switch controls: one opens terminal A and one shorts the wiper to terminal B.

The serial pins are asynchronous to the system clock `clk`. They are resynchronised and edge-detected inside the block, so the serial clock must run well below `clk`. A serial data output, taken from the far end of the input shift register, lets several devices share one select line in a daisy chain. A shutdown input forces every channel into its open and shorted state but keeps the latched codes. On exit, the earlier settings return. A synchronous reset puts every wiper at midscale.

Top module: `quad_dpot_ctrl`

## Requirements
- R1: After `rst`, every channel's tap code is 6'h20 (midscale), `open_a` and `short_wb` are all 0, and `sdo` is 0.
- R2: A frame is the bits clocked on rising `sclk` edges while `cs_n` is low, most significant bit first. Frame bit 7 and bit 6 form the channel number (bit 7 is the high bit). Bits 5..0 are the wiper code. Channel k's tap code sits at `tap_code[6k+5:6k]`, and the other channels stay unchanged.
- R3: When `cs_n` rises after exactly 8 rising `sclk` edges, the addressed latch is loaded. A frame with any other edge count (for example 7, 9 or 16) leaves every latch unchanged.
- R4: No tap code changes while bits are still shifting, even after 8 edges, until `cs_n` rises.
- R5: `sdo` changes only after a falling `sclk` edge. After the falling edge that follows rising edge n (n at least 8), it presents the bit clocked in on rising edge n-7. A bit therefore comes out 8 clocks after it went in.
- R6: While `shdn` is high, every `open_a` and `short_wb` bit is 1 and every tap code is 0.
- R7: When `shdn` goes low, each tap code returns to the code latched before shutdown, and `open_a` and `short_wb` return to 0.
- R8: A valid frame received during shutdown updates the stored code without changing the forced outputs. That code is applied when shutdown ends.
- R9: `sclk` edges while `cs_n` is high do not shift data, do not move `sdo`, and do not count toward the next frame.
- R10: `rst` asserted after writes returns every channel to midscale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; presets wipers to midscale |
| cs_n | input | 1 | Serial select, active low; rising edge commits a frame |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| shdn | input | 1 | Shutdown request, active high |
| sdo | output | 1 | Serial data out for daisy chaining |
| tap_code | output | 24 | Four 6-bit tap-select codes, channel k at bits 6k+5..6k |
| open_a | output | 4 | Per channel: open terminal A |
| short_wb | output | 4 | Per channel: short wiper to terminal B |

## Verification
The hardest situation to reach is the path that writes a latch without touching the outputs: the code is stored during shutdown while the outputs stay forced, and it only becomes visible when shutdown is released. The bench raises `shdn` and sends a valid frame to one channel. It confirms that the outputs stay at 0 with both switch controls set, then drops `shdn` and expects the new code on that channel and the old codes on the rest. The daisy-chain output is checked by sending a 16-edge frame, which must also be discarded. Around every falling edge, `sdo` is sampled just before the edge and again just after it.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int CH_N     = 4;
  localparam int CODE_W   = 6;
  localparam int ADDR_W   = $clog2(CH_N);
  localparam int FRAME_W  = ADDR_W + CODE_W;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  typedef struct packed {
    logic [ADDR_W-1:0] chan;
    logic [CODE_W-1:0] code;
  } wr_cmd_t;
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
  parameter int PINS   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] lvl_o,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_pin
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin_i[g]};
      end
      assign lvl_o[g]  = chain[STAGES-1];
      assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
      assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/dpot_frame_rx.sv
module dpot_frame_rx
  import dpot_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sel_n,
  input  logic    sel_rise,
  input  logic    sel_fall,
  input  logic    sck_rise,
  input  logic    sck_fall,
  input  logic    din,
  output logic    load_o,
  output wr_cmd_t cmd_o,
  output logic    sdo_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      edges <= '0;
    end else begin
      if (sel_fall) edges <= '0;
      else if (sck_rise && !sel_n && edges != CNT_OVER) edges <= edges + 1'b1;
      if (sck_rise && !sel_n) shreg <= {shreg[FRAME_W-2:0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo_o <= 1'b0;
    else if (sck_fall && !sel_n) sdo_o <= shreg[FRAME_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_o <= 1'b0;
      cmd_o  <= '0;
    end else begin
      load_o <= sel_rise && (edges == CNT_FULL);
      if (sel_rise) cmd_o <= shreg;
    end
  end

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    edges <= CNT_OVER);
  p_idle_no_shift_r9: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> $stable(shreg));
  p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_o) |-> $past(sck_fall));
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank
  import dpot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shdn_i,
  input  logic                     load_i,
  input  wr_cmd_t                  cmd_i,
  output logic [CH_N*CODE_W-1:0]   tap_o,
  output logic [CH_N-1:0]          open_a_o,
  output logic [CH_N-1:0]          short_wb_o
);
  logic [CODE_W-1:0] lat [CH_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH_N; i++) lat[i] <= MID_CODE;
    end else if (load_i) begin
      lat[cmd_i.chan] <= cmd_i.code;
    end
  end

  genvar g;
  generate
    for (g = 0; g < CH_N; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          tap_o[g*CODE_W +: CODE_W] <= MID_CODE;
          open_a_o[g]   <= 1'b0;
          short_wb_o[g] <= 1'b0;
        end else begin
          tap_o[g*CODE_W +: CODE_W] <= shdn_i ? '0 : lat[g];
          open_a_o[g]   <= shdn_i;
          short_wb_o[g] <= shdn_i;
        end
      end

      p_restore_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(shdn_i) && !load_i) |=> (tap_o[g*CODE_W +: CODE_W] == lat[g]));
      p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(lat[g]));
    end
  endgenerate

  p_forced_r6: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> (&open_a_o) && (&short_wb_o) && (tap_o == '0));
endmodule

// File: rtl/quad_dpot_ctrl.sv
module quad_dpot_ctrl
  import dpot_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   shdn,
  output logic                   sdo,
  output logic [CH_N*CODE_W-1:0] tap_code,
  output logic [CH_N-1:0]        open_a,
  output logic [CH_N-1:0]        short_wb
);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0] lvl, rise, fall;
  logic             load;
  wr_cmd_t          cmd;

  dpot_pin_sync #(.PINS(PIN_N), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({shdn, sdi, sclk, cs_n}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  dpot_frame_rx u_rx (
    .clk(clk), .rst(rst),
    .sel_n(lvl[0]), .sel_rise(rise[0]), .sel_fall(fall[0]),
    .sck_rise(rise[1]), .sck_fall(fall[1]),
    .din(lvl[2]),
    .load_o(load), .cmd_o(cmd), .sdo_o(sdo)
  );

  dpot_wiper_bank u_bank (
    .clk(clk), .rst(rst),
    .shdn_i(lvl[3]), .load_i(load), .cmd_i(cmd),
    .tap_o(tap_code), .open_a_o(open_a), .short_wb_o(short_wb)
  );

  p_reset_mid_r1: assert property (@(posedge clk)
    $past(rst) |-> (tap_code == {CH_N{MID_CODE}}) && (sdo == 1'b0));
endmodule

// File: tb/quad_dpot_ctrl_tb.sv
module quad_dpot_ctrl_tb;
  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sdi = 0, shdn = 0;
  logic sdo;
  logic [23:0] tap_code;
  logic [3:0] open_a, short_wb;
  int checks = 0, failures = 0;
  logic [5:0] exp_tap [4];
  localparam int HP = 6;

  always #2 clk = ~clk;

  quad_dpot_ctrl u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn(shdn), .sdo(sdo), .tap_code(tap_code), .open_a(open_a), .short_wb(short_wb));

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_taps(input string tag);
    for (int k = 0; k < 4; k++)
      chk(tap_code[k*6 +: 6] == exp_tap[k], tag, tap_code[k*6 +: 6], exp_tap[k]);
  endtask

  task automatic send(input logic [15:0] data, input int n, input bit raise);
    cs_n = 0; wc(HP);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = data[i]; wc(HP);
      sclk = 1; wc(HP);
      sclk = 0;
    end
    wc(HP);
    if (raise) begin cs_n = 1; wc(2 * HP); end
  endtask

  task automatic t_reset;
    rst = 1; wc(3); rst = 0; wc(2);
    for (int k = 0; k < 4; k++) exp_tap[k] = 6'h20;
    chk_taps("R1 tap midscale");
    chk(open_a == 0 && short_wb == 0, "R1 switches", {open_a, short_wb}, 0);
    chk(sdo == 0, "R1 sdo", sdo, 0);
  endtask

  task automatic t_write;
    send({8'h00, 2'd0, 6'h05}, 8, 1); exp_tap[0] = 6'h05;
    chk_taps("R2 ch0 write");
    send({8'h00, 2'd3, 6'h3F}, 8, 1); exp_tap[3] = 6'h3F;
    chk_taps("R2 ch3 write");
    send({8'h00, 2'd1, 6'h2A}, 8, 1); exp_tap[1] = 6'h2A;
    send({8'h00, 2'd2, 6'h00}, 8, 1); exp_tap[2] = 6'h00;
    chk_taps("R2 ch1 ch2 write");
  endtask

  task automatic t_bad_count;
    send({8'h00, 2'd0, 6'h11}, 7, 1);
    chk_taps("R3 seven edges discarded");
    send({7'h00, 2'd1, 6'h12, 1'b1}, 9, 1);
    chk_taps("R3 nine edges discarded");
  endtask

  task automatic t_midframe;
    send({8'h00, 2'd2, 6'h1B}, 8, 0);
    wc(20);
    chk_taps("R4 no update before cs rise");
    cs_n = 1; wc(2 * HP); exp_tap[2] = 6'h1B;
    chk_taps("R4 update after cs rise");
  endtask

  task automatic t_sdo;
    logic [15:0] s = 16'hA53C;
    cs_n = 0; wc(HP);
    for (int i = 1; i <= 16; i++) begin
      sdi = s[16 - i]; wc(HP);
      sclk = 1; wc(HP);
      if (i >= 9) chk(sdo == s[24 - i], "R5 sdo held before fall", sdo, s[24 - i]);
      sclk = 0; wc(HP);
      if (i >= 8) chk(sdo == s[23 - i], "R5 sdo after fall", sdo, s[23 - i]);
    end
    cs_n = 1; wc(2 * HP);
    chk_taps("R3 sixteen edges discarded");
  endtask

  task automatic t_cs_high;
    logic s0;
    s0 = sdo;
    sdi = 1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1; wc(HP); sclk = 0; wc(HP);
    end
    chk(sdo == s0, "R9 sdo unchanged with cs high", sdo, s0);
    chk_taps("R9 taps unchanged with cs high");
    send({8'h00, 2'd0, 6'h2C}, 8, 1); exp_tap[0] = 6'h2C;
    chk_taps("R9 next frame counted from zero");
  endtask

  task automatic t_shutdown;
    shdn = 1; wc(6);
    chk(tap_code == 0, "R6 taps forced zero", tap_code, 0);
    chk(open_a == 4'hF && short_wb == 4'hF, "R6 switches set", {open_a, short_wb}, 8'hFF);
    send({8'h00, 2'd2, 6'h11}, 8, 1); exp_tap[2] = 6'h11;
    chk(tap_code == 0, "R8 forced during shutdown write", tap_code, 0);
    chk(open_a == 4'hF, "R8 open held", open_a, 4'hF);
    shdn = 0; wc(6);
    chk_taps("R7 R8 restored after shutdown");
    chk(open_a == 0 && short_wb == 0, "R7 switches cleared", {open_a, short_wb}, 0);
  endtask

  task automatic t_reset_again;
    rst = 1; wc(2); rst = 0; wc(2);
    for (int k = 0; k < 4; k++) exp_tap[k] = 6'h20;
    chk_taps("R10 reset after writes");
  endtask

  initial begin
    fork
      begin
        wc(1);
        t_reset;
        t_write;
        t_bad_count;
        t_midframe;
        t_sdo;
        t_cs_high;
        t_shutdown;
        t_reset_again;
      end
      begin
        wc(100000);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule